// File: doc/BRIEF.md
# Delayed trigger sequencer

This block sequences the trigger decisions of a sampling acquisition system. A host programs it through an eight-command write port: a 3-bit address picks the command and an 8-bit data byte carries the operand. One command loads a mode byte, two commands set the low and high bytes of a 16-bit delay, and one command copies those two bytes into the delay counter. The other commands restart an acquisition, force a trigger, clear the latches, or do nothing.

After a restart the sequencer waits for the acquisition front end to report that the pretrigger samples are in. It then watches one of four A-trigger inputs. The first A event produces a one-cycle jitter-trigger pulse and starts a countdown. The countdown is clocked by a delay-tick enable, by B events, or by further A events, depending on the mode byte. When the count runs out, the record trigger fires at once, or the block waits for the next B event and fires on that. If the pretrigger-done signal drops, the block stops issuing triggers until the host restarts it.

All trigger inputs and pretrigger-done are synchronised inside the block. Each trigger input is edge-detected, so an input that stays high counts as a single event.

Top module: `trig_seq`

## Requirements
- R1: While reset is active, and after it is released, `seq_state` reads 0 (idle), and `jit_trig` and `rec_trig` are low.
- R2: A write with `wr_addr` = 0 moves the sequencer to state 1 (pretrigger wait) on the next clock, from any state. A write with `wr_addr` = 6 changes neither the state nor any latch. The state codes are: 0 idle, 1 pretrigger wait, 2 A wait, 3 counting, 4 B wait, 5 done.
- R3: In state 1, trigger inputs produce no jitter trigger and no record trigger. The block moves to state 2 once `pt_done` has been high for the two synchroniser clocks.
- R4: In state 2, a rising edge on `a_trig[m[1:0]]` (m is the mode byte) pulses `jit_trig` for exactly one cycle, loads the delay counter and enters state 3. `jit_trig` is high three clocks after the input edge is driven. Edges on the other A inputs are ignored.
- R5: With m[5:4] = 0 (run after), each cycle that `dly_tick` is high decrements the count. `rec_trig` pulses in the clock after the count reaches zero, and the block enters state 5. A delay of 0 fires one clock after `jit_trig`.
- R6: With m[5:4] = 2 (event delay), rising edges on `b_trig[m[3:2]]` decrement the count and `dly_tick` is ignored. Zero then fires the record trigger as in R5.
- R7: With m[5:4] = 1 (trigger after), the count runs on `dly_tick` and B edges are ignored while counting. Reaching zero enters state 4, and the next selected B edge pulses `rec_trig` three clocks after it is driven.
- R8: When `pt_done` is low in state 2, 3 or 4, the block enters state 5 without a record trigger. State 5 holds, and produces no triggers, until a restart.
- R9: A write with `wr_addr` = 1 in states 1 to 4 pulses `rec_trig` on the next clock and enters state 5. The same write in state 0 or 5 has no effect.
- R10: With m[6] = 1, the A edge in state 2 pulses `jit_trig` and `rec_trig` in the same cycle and enters state 5, with no countdown.
- R11: With m[7] = 1 and m[5:4] not equal to 2, the count runs on selected A edges instead of `dly_tick`.
- R12: Writes with `wr_addr` 3 and 4 latch the low and high delay bytes. `wr_addr` 5 copies {high, low} into the counter reload value. `wr_addr` 2 loads the mode byte. `wr_addr` 7 clears the mode byte and both delay bytes, but not the reload value.
- R13: A trigger input held high for many cycles counts as one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per command |
| wr_addr | input | 3 | Command select |
| wr_data | input | 8 | Command operand |
| pt_done | input | 1 | Pretrigger samples complete (level) |
| a_trig | input | 4 | A-trigger candidate inputs |
| b_trig | input | 4 | B-trigger candidate inputs |
| dly_tick | input | 1 | Delay clock enable, one decrement per high cycle |
| jit_trig | output | 1 | One-cycle pulse on the qualifying A event |
| rec_trig | output | 1 | One-cycle record trigger pulse |
| seq_state | output | 3 | Current sequencer state code |

## Verification
The bench builds the block with its default parameters: a 16-bit delay and two synchroniser stages. It sweeps every A source against each of the three delay modes with delays from 0 to 5. In every run it injects events from the source that should be ignored, and it checks the exact cycle of each jitter and record pulse against the stated latencies. A 259-tick delay, driven by a held `dly_tick`, exercises both delay bytes. Directed runs cover forced triggers, pretrigger loss, direct record, A-event counting, held inputs and latch clearing.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  localparam int SEL_W  = 2;
  localparam int N_SRC  = 1 << SEL_W;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAIT_PT = 3'd1,
    ST_WAIT_A  = 3'd2,
    ST_COUNT   = 3'd3,
    ST_WAIT_B  = 3'd4,
    ST_DONE    = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    DM_RUNS   = 2'd0,
    DM_TRIG   = 2'd1,
    DM_EVENTS = 2'd2,
    DM_SPARE  = 2'd3
  } dly_mode_e;

  typedef enum logic [2:0] {
    CMD_RESTART  = 3'd0,
    CMD_FORCE    = 3'd1,
    CMD_MODE     = 3'd2,
    CMD_DLY_LO   = 3'd3,
    CMD_DLY_HI   = 3'd4,
    CMD_DLY_XFER = 3'd5,
    CMD_NOP      = 3'd6,
    CMD_CLEAR    = 3'd7
  } host_cmd_e;

  typedef struct packed {
    logic             multi;
    logic             direct;
    dly_mode_e        dmode;
    logic [SEL_W-1:0] b_sel;
    logic [SEL_W-1:0] a_sel;
  } mode_t;

endpackage

// File: rtl/trig_rst_sync.sv
module trig_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] rs_q;
  logic [1:0] rs_d;

  always_comb rs_d = {rs_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= rs_d;
  end

  assign rst_n_sync = rs_q[1];

endmodule

// File: rtl/trig_edge_sync.sv
// Multi-stage synchroniser; RISE selects a rising-edge pulse or the level.
module trig_edge_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter bit RISE   = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] ev_o
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb stg_d = {stg_q[STAGES-2:0], d_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  generate
    if (RISE) begin : g_rise
      logic [W-1:0] prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stg_q[STAGES-1];
      end
      assign ev_o = stg_q[STAGES-1] & ~prev_q;
    end else begin : g_level
      assign ev_o = stg_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/trig_host_regs.sv
module trig_host_regs
  import trig_seq_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output mode_t            mode_o,
  output logic [DLY_W-1:0] dly_cfg_o,
  output logic             restart_o,
  output logic             force_o,
  output logic             xfer_o
);

  localparam int HI_W = DLY_W - BYTE_W;

  host_cmd_e         cmd;
  mode_t             mode_q, mode_d;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0]   hi_q, hi_d;

  assign cmd = host_cmd_e'(wr_addr);

  always_comb begin
    restart_o = wr_en && (cmd == CMD_RESTART);
    force_o   = wr_en && (cmd == CMD_FORCE);
    xfer_o    = wr_en && (cmd == CMD_DLY_XFER);
  end

  always_comb begin
    mode_d = mode_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    if (wr_en) begin
      case (cmd)
        CMD_MODE:   mode_d = mode_t'(wr_data);
        CMD_DLY_LO: lo_d   = wr_data;
        CMD_DLY_HI: hi_d   = wr_data[HI_W-1:0];
        CMD_CLEAR: begin
          mode_d = '0;
          lo_d   = '0;
          hi_d   = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      mode_q <= mode_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end

  assign mode_o    = mode_q;
  assign dly_cfg_o = {hi_q, lo_q};

endmodule

// File: rtl/trig_dly_counter.sv
module trig_dly_counter #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_i,
  input  logic [DLY_W-1:0] cfg_i,
  input  logic             start_i,
  input  logic             dec_i,
  output logic             zero_o
);

  logic [DLY_W-1:0] reload_q, reload_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;

  always_comb begin
    reload_d = xfer_i ? cfg_i : reload_q;
    cnt_d    = cnt_q;
    if (start_i)                   cnt_d = reload_q;
    else if (dec_i && (cnt_q != '0)) cnt_d = cnt_q - DLY_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else begin
      reload_q <= reload_d;
      cnt_q    <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/trig_seq_fsm.sv
module trig_seq_fsm
  import trig_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart_i,
  input  logic       force_i,
  input  logic       pt_i,
  input  logic       a_ev_i,
  input  logic       b_ev_i,
  input  logic       tick_i,
  input  dly_mode_e  dmode_i,
  input  logic       direct_i,
  input  logic       multi_i,
  input  logic       zero_i,
  output seq_state_e state_o,
  output logic       jit_o,
  output logic       rec_o,
  output logic       start_o,
  output logic       dec_o
);

  seq_state_e state_q, state_d;
  logic       jit_q, jit_d;
  logic       rec_q, rec_d;
  logic       dec_src;
  logic       armed;

  always_comb begin
    if (dmode_i == DM_EVENTS) dec_src = b_ev_i;
    else if (multi_i)         dec_src = a_ev_i;
    else                      dec_src = tick_i;
    armed = (state_q == ST_WAIT_PT) || (state_q == ST_WAIT_A) ||
            (state_q == ST_COUNT)   || (state_q == ST_WAIT_B);
  end

  always_comb begin
    state_d = state_q;
    jit_d   = 1'b0;
    rec_d   = 1'b0;
    start_o = 1'b0;
    dec_o   = 1'b0;
    if (restart_i) begin
      state_d = ST_WAIT_PT;
    end else if (force_i && armed) begin
      rec_d   = 1'b1;
      state_d = ST_DONE;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: ;
        ST_WAIT_PT: if (pt_i) state_d = ST_WAIT_A;
        ST_WAIT_A: begin
          if (!pt_i) begin
            state_d = ST_DONE;
          end else if (a_ev_i) begin
            jit_d = 1'b1;
            if (direct_i) begin
              rec_d   = 1'b1;
              state_d = ST_DONE;
            end else begin
              start_o = 1'b1;
              state_d = ST_COUNT;
            end
          end
        end
        ST_COUNT: begin
          if (!pt_i) begin
            state_d = ST_DONE;
          end else if (zero_i) begin
            if (dmode_i == DM_TRIG) begin
              state_d = ST_WAIT_B;
            end else begin
              rec_d   = 1'b1;
              state_d = ST_DONE;
            end
          end else begin
            dec_o = dec_src;
          end
        end
        ST_WAIT_B: begin
          if (!pt_i) begin
            state_d = ST_DONE;
          end else if (b_ev_i) begin
            rec_d   = 1'b1;
            state_d = ST_DONE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      jit_q   <= 1'b0;
      rec_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      jit_q   <= jit_d;
      rec_q   <= rec_d;
    end
  end

  assign state_o = state_q;
  assign jit_o   = jit_q;
  assign rec_o   = rec_q;

endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int DLY_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             pt_done,
  input  logic [N_SRC-1:0] a_trig,
  input  logic [N_SRC-1:0] b_trig,
  input  logic             dly_tick,
  output logic             jit_trig,
  output logic             rec_trig,
  output logic [2:0]       seq_state
);

  logic             rst_n_sync;
  logic [N_SRC-1:0] a_rise, b_rise;
  logic             pt_lvl;
  mode_t            mode;
  logic [DLY_W-1:0] dly_cfg;
  logic             restart, force_trig, xfer;
  logic             start, dec, zero;
  seq_state_e       st;

  trig_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync));

  trig_edge_sync #(.W(N_SRC), .STAGES(SYNC_STAGES), .RISE(1'b1)) u_sync_a (
    .clk(clk), .rst_n(rst_n_sync), .d_in(a_trig), .ev_o(a_rise));

  trig_edge_sync #(.W(N_SRC), .STAGES(SYNC_STAGES), .RISE(1'b1)) u_sync_b (
    .clk(clk), .rst_n(rst_n_sync), .d_in(b_trig), .ev_o(b_rise));

  trig_edge_sync #(.W(1), .STAGES(SYNC_STAGES), .RISE(1'b0)) u_sync_pt (
    .clk(clk), .rst_n(rst_n_sync), .d_in(pt_done), .ev_o(pt_lvl));

  trig_host_regs #(.DLY_W(DLY_W)) u_regs (
    .clk(clk), .rst_n(rst_n_sync), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_o(mode), .dly_cfg_o(dly_cfg),
    .restart_o(restart), .force_o(force_trig), .xfer_o(xfer));

  trig_dly_counter #(.DLY_W(DLY_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_sync), .xfer_i(xfer), .cfg_i(dly_cfg),
    .start_i(start), .dec_i(dec), .zero_o(zero));

  trig_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_sync), .restart_i(restart), .force_i(force_trig),
    .pt_i(pt_lvl), .a_ev_i(a_rise[mode.a_sel]), .b_ev_i(b_rise[mode.b_sel]),
    .tick_i(dly_tick), .dmode_i(mode.dmode), .direct_i(mode.direct),
    .multi_i(mode.multi), .zero_i(zero), .state_o(st), .jit_o(jit_trig),
    .rec_o(rec_trig), .start_o(start), .dec_o(dec));

  assign seq_state = st;

endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk (
  input logic       clk,
  input logic       rst_n_i,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic       jit_trig,
  input logic       rec_trig,
  input logic [2:0] seq_state
);

  logic restart_wr;
  logic force_wr;
  assign restart_wr = wr_en && (wr_addr == 3'd0);
  assign force_wr   = wr_en && (wr_addr == 3'd1);

  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n_i)
    restart_wr |=> (seq_state == 3'd1));

  a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n_i)
    (seq_state == 3'd1) |=> !jit_trig);

  a_r4_jit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n_i)
    jit_trig |=> !jit_trig);

  a_r4_jit_origin: assert property (@(posedge clk) disable iff (!rst_n_i)
    jit_trig |-> ($past(seq_state) == 3'd2));

  a_r5_rec_ends: assert property (@(posedge clk) disable iff (!rst_n_i)
    rec_trig |-> (seq_state == 3'd5));

  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n_i)
    ((seq_state == 3'd5) && !restart_wr) |=>
      ((seq_state == 3'd5) && !rec_trig && !jit_trig));

  a_r9_force: assert property (@(posedge clk) disable iff (!rst_n_i)
    (force_wr && (seq_state >= 3'd1) && (seq_state <= 3'd4)) |=>
      (rec_trig && (seq_state == 3'd5)));

endmodule

bind trig_seq trig_seq_chk u_chk (
  .clk(clk), .rst_n_i(rst_n_sync), .wr_en(wr_en), .wr_addr(wr_addr),
  .jit_trig(jit_trig), .rec_trig(rec_trig), .seq_state(seq_state));

// File: tb/tb_trig_seq.sv
`timescale 1ns/1ps
module tb_trig_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pt_done = 1'b0;
  logic [3:0] a_trig = '0;
  logic [3:0] b_trig = '0;
  logic       dly_tick = 1'b0;
  logic       jit_trig, rec_trig;
  logic [2:0] seq_state;

  int cyc = 0, checks = 0, errors = 0;
  int jit_n = 0, rec_n = 0, jit_at = -1, rec_at = -1, last_c = 0;

  trig_seq dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pt_done(pt_done), .a_trig(a_trig), .b_trig(b_trig),
    .dly_tick(dly_tick), .jit_trig(jit_trig), .rec_trig(rec_trig),
    .seq_state(seq_state));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (jit_trig) begin jit_n = jit_n + 1; jit_at = cyc; end
    if (rec_trig) begin rec_n = rec_n + 1; rec_at = cyc; end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    last_c = cyc;
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_a(input int idx);
    @(negedge clk); last_c = cyc; a_trig[idx] = 1'b1;
    @(negedge clk); a_trig[idx] = 1'b0;
  endtask

  task automatic pulse_b(input int idx);
    @(negedge clk); last_c = cyc; b_trig[idx] = 1'b1;
    @(negedge clk); b_trig[idx] = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); last_c = cyc; dly_tick = 1'b1;
    @(negedge clk); dly_tick = 1'b0;
  endtask

  task automatic arm(input int mode, input int dly);
    pt_done = 1'b0; idle(3);
    wr(2, mode); wr(3, dly & 255); wr(4, dly >> 8); wr(5, 0);
    wr(0, 0);
    chk("R2", "state after restart", seq_state, 1);
    pt_done = 1'b1; idle(3);
    chk("R3", "state after pretrigger done", seq_state, 2);
  endtask

  task automatic run_case(input int dm, input int src, input int d);
    int bsrc, j0, r0, c_end;
    bsrc = (src + 1) % 4;
    arm((dm << 4) | (bsrc << 2) | src, d);
    j0 = jit_n; r0 = rec_n;
    pulse_a((src + 2) % 4); idle(4);
    chk("R4", "unselected A ignored", jit_n, j0);
    pulse_a(src); c_end = last_c; idle(4);
    chk("R4", "jit count", jit_n, j0 + 1);
    chk("R4", "jit cycle", jit_at, c_end + 3);
    if (d == 0) begin
      if (dm == 1) chk("R7", "zero delay reaches B wait", seq_state, 4);
      else begin
        chk("R5", "zero delay rec count", rec_n, r0 + 1);
        chk("R5", "zero delay rec cycle", rec_at, jit_at + 1);
      end
    end else begin
      for (int i = 0; i < d; i++) begin
        if (dm == 2) pulse_tick(); else pulse_b(bsrc);
        idle(3);
        chk(dm == 2 ? "R6" : "R7", "wrong source ignored", rec_n, r0);
        if (dm == 2) pulse_b(bsrc); else pulse_tick();
        c_end = last_c; idle(4);
        if (i < d - 1) chk("R5", "no early rec", rec_n, r0);
      end
      if (dm == 0) begin
        chk("R5", "run-after rec count", rec_n, r0 + 1);
        chk("R5", "run-after rec cycle", rec_at, c_end + 2);
      end else if (dm == 2) begin
        chk("R6", "event-delay rec count", rec_n, r0 + 1);
        chk("R6", "event-delay rec cycle", rec_at, c_end + 4);
      end else begin
        chk("R7", "count done waits for B", seq_state, 4);
        chk("R7", "no rec before B", rec_n, r0);
      end
    end
    if (dm == 1) begin
      pulse_b(bsrc); c_end = last_c; idle(4);
      chk("R7", "trig-after rec count", rec_n, r0 + 1);
      chk("R7", "trig-after rec cycle", rec_at, c_end + 3);
    end
    chk("R5", "ends in done", seq_state, 5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int j0, r0, c0;
    idle(2);
    chk("R1", "state in reset", seq_state, 0);
    chk("R1", "rec in reset", rec_trig, 0);
    rst_n = 1'b1; idle(5);
    chk("R1", "state after reset", seq_state, 0);
    chk("R1", "jit after reset", jit_trig, 0);

    // R9: force ignored in idle
    r0 = rec_n; wr(1, 0); idle(2);
    chk("R9", "force in idle state", seq_state, 0);
    chk("R9", "force in idle rec", rec_n, r0);

    // R3: triggers ignored before pretrigger done; R9 force in state 1
    wr(2, 0); wr(0, 0); j0 = jit_n;
    pulse_a(0); idle(5);
    chk("R3", "A before pretrigger", jit_n, j0);
    chk("R3", "still waiting", seq_state, 1);
    r0 = rec_n; wr(1, 0); c0 = last_c; idle(2);
    chk("R9", "force in pretrigger wait", rec_at, c0 + 1);
    chk("R9", "force state", seq_state, 5);
    chk("R9", "force rec count", rec_n, r0 + 1);
    r0 = rec_n; wr(1, 0); idle(2);
    chk("R9", "force in done ignored", rec_n, r0);

    for (int dm = 0; dm < 3; dm++)
      for (int src = 0; src < 4; src++)
        for (int d = 0; d < 6; d++)
          run_case(dm, src, d);

    // R13: held inputs count once (event-delay, A on 0, B on 1, delay 2)
    arm((2 << 4) | (1 << 2) | 0, 2);
    j0 = jit_n; r0 = rec_n;
    @(negedge clk); a_trig[0] = 1'b1; idle(10); a_trig[0] = 1'b0; idle(3);
    chk("R13", "held A jit count", jit_n, j0 + 1);
    @(negedge clk); b_trig[1] = 1'b1; idle(10); b_trig[1] = 1'b0; idle(3);
    chk("R13", "held B one decrement", rec_n, r0);
    chk("R13", "still counting", seq_state, 3);
    pulse_b(1); c0 = last_c; idle(4);
    chk("R13", "second B fires", rec_at, c0 + 4);

    // R8: pretrigger loss while counting
    arm(0, 5); pulse_a(0); idle(4); r0 = rec_n;
    pt_done = 1'b0; idle(4);
    chk("R8", "pt loss in count", seq_state, 5);
    for (int i = 0; i < 6; i++) pulse_tick();
    idle(3);
    chk("R8", "no rec after pt loss", rec_n, r0);
    // R8: pretrigger loss in A wait
    arm(0, 0); pt_done = 1'b0; idle(4);
    chk("R8", "pt loss in A wait", seq_state, 5);
    j0 = jit_n; pulse_a(0); idle(4);
    chk("R8", "no jit in done", jit_n, j0);
    // R8: pretrigger loss in B wait
    arm(1 << 4, 0); pulse_a(0); idle(4);
    chk("R8", "in B wait", seq_state, 4);
    r0 = rec_n; pt_done = 1'b0; idle(4); pulse_b(0); idle(4);
    chk("R8", "pt loss in B wait", seq_state, 5);
    chk("R8", "no rec after B", rec_n, r0);

    // R2: restart from counting; R9: force in counting
    arm(0, 9); pulse_a(0); idle(4);
    wr(0, 0);
    chk("R2", "restart from count", seq_state, 1);
    pt_done = 1'b1; idle(3); pulse_a(0); idle(4);
    r0 = rec_n; wr(1, 0); c0 = last_c; idle(2);
    chk("R9", "force in count cycle", rec_at, c0 + 1);
    chk("R9", "force in count state", seq_state, 5);

    // R10: direct record
    arm(8'h40 | 2, 7); j0 = jit_n; r0 = rec_n;
    pulse_a(2); c0 = last_c; idle(4);
    chk("R10", "direct jit cycle", jit_at, c0 + 3);
    chk("R10", "direct rec cycle", rec_at, c0 + 3);
    chk("R10", "direct state", seq_state, 5);

    // R11: multi-event counting on A
    arm(8'h80 | 3, 2); r0 = rec_n;
    pulse_a(3); idle(3); pulse_a(3); idle(3); pulse_tick(); idle(3);
    chk("R11", "tick ignored, no rec yet", rec_n, r0);
    pulse_a(3); c0 = last_c; idle(4);
    chk("R11", "A-counted rec cycle", rec_at, c0 + 4);

    // R12: byte latches, no-op write, held tick for 0x0103
    pt_done = 1'b0; idle(3);
    wr(2, 0); wr(3, 8'h03); wr(4, 8'h01); wr(6, 8'hFF); wr(5, 0);
    wr(0, 0); pt_done = 1'b1; idle(3);
    pulse_a(0); idle(4);
    wr(6, 0);
    chk("R2", "no-op keeps state", seq_state, 3);
    r0 = rec_n;
    @(negedge clk); c0 = cyc; dly_tick = 1'b1;
    repeat (259) @(negedge clk);
    dly_tick = 1'b0; idle(3);
    chk("R12", "two-byte delay rec", rec_at, c0 + 260);
    chk("R12", "two-byte rec count", rec_n, r0 + 1);

    // R12: clear command wipes mode and bytes
    pt_done = 1'b0; idle(3);
    wr(2, 8'h41); wr(3, 8'h09); wr(7, 0); wr(5, 0);
    wr(0, 0); pt_done = 1'b1; idle(3);
    j0 = jit_n; pulse_a(0); c0 = last_c; idle(4);
    chk("R12", "cleared mode selects A0", jit_n, j0 + 1);
    chk("R12", "cleared delay is zero", rec_at, jit_at + 1);
    chk("R12", "cleared delay jit cycle", jit_at, c0 + 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule